// File: doc/BRIEF.md
# SMBus Register-Pointer Slave

This block is the serial front end of a small management device. It watches an SMBus/I2C-style two-wire bus and answers only to its own 7-bit address. Behind it sits a plain register file that is reached through one byte-wide pointer. A write transaction always loads the pointer from its first data byte. If the write has a second data byte, that byte is stored into the register the pointer selects. A read transaction returns the byte at the current pointer, so a master can read the same register many times without sending a new pointer.

The address has a fixed five-bit prefix. Its two low bits come from a three-level strap, which reaches the block as a two-bit code. The strap is captured once, right after reset. SCL and SDA are oversampled on the system clock through a synchronizer. SDA is driven open-drain, as a pull-low enable. The register file sees the pointer as its address, a write strobe and write data, and it returns read data combinationally for the current pointer.

Top module: `smbus_ptr_slave`

## Requirements
- R1: After reset, SDA is released (`sdaDriveLow`=0), `regWrEn` is 0 and the pointer on `regAddr` is 0.
- R2: The slave address is {01011, A1, A0}. A1A0 comes from `strapCode`: code 00 (grounded) gives 00, code 10 (tied to supply) gives 01, and codes 01 and 11 (open) give 10. The open strap therefore gives 0101110 (0x2E).
- R3: The strap is captured in the first clock after reset. Changing `strapCode` afterwards does not change the address until the next reset.
- R4: START (SDA falls while SCL is high) begins an address phase from any state. STOP (SDA rises while SCL is high) returns the slave to idle with SDA released. The slave changes its SDA drive only while SCL is low.
- R5: The slave pulls SDA low during the ninth clock after a matching address byte and after every byte it receives in a write.
- R6: In a write, the first data byte loads the pointer, which shows on `regAddr`. The second data byte is presented on `regWrData` with a single-cycle `regWrEn` to the register the pointer selects.
- R7: A write that carries only the pointer byte raises no `regWrEn` and leaves every register unchanged.
- R8: A read returns the byte at the current pointer, MSB first. No pointer write is needed first, and the pointer is kept from one transaction to the next.
- R9: Write bytes after the second are acknowledged but discarded: no `regWrEn` is raised and the pointer does not change.
- R10: A repeated START after a pointer write begins a new transaction. A read that follows it returns the selected register.
- R11: An address byte that does not match gets no acknowledge. The rest of that transaction changes neither the pointer nor any register.
- R12: When the master NACKs a read byte, the slave releases SDA and waits for STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapCode | input | 2 | Encoded three-level address strap |
| sdaDriveLow | output | 1 | Pull SDA low when 1; release when 0 |
| regAddr | output | PTR_W | Current pointer, used as register address |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Data for the register write |
| regRdData | input | 8 | Contents of the register at `regAddr` |

## Verification
The bench sweeps all 128 address bytes with the strap open and tries all three strap levels. A decode error would acknowledge a stranger's address or miss its own. It changes the strap after reset, which catches a design that samples the strap continuously. A pointer-only write and a four-byte write check that the write strobe fires once and only for the second byte. A counter off by one would corrupt the register that follows. A read after a repeated START, and a transaction sent to a foreign address, show whether the pointer survives when it should and stays untouched when the slave must ignore the bus.

// File: rtl/smbus_ptr_pkg.sv
package smbus_ptr_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } busState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic clearShift;
    logic ptrLoad;
    logic regWrite;
    logic txLoad;
    logic txShift;
    logic driveAck;
    logic driveData;
  } dpStrobe_t;

  // Strap code -> {A1, A0}; code 00 ground, 10 supply, others open
  function automatic logic [1:0] decodeStrap(input logic [1:0] code);
    unique case (code)
      2'b00:   decodeStrap = 2'b00;
      2'b10:   decodeStrap = 2'b01;
      default: decodeStrap = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/smbus_ptr_ctrl.sv
module smbus_ptr_ctrl
  import smbus_ptr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      sdaLvl,
  input  logic      addrMatch,
  input  logic      rwBit,
  output dpStrobe_t strobe
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_BITS - 1);

  busState_t        state, nextState;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [1:0]       byteIdx, idxNext;
  logic             ackLow, ackNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      ackLow  <= 1'b0;
    end else begin
      state   <= nextState;
      bitCnt  <= cntNext;
      byteIdx <= idxNext;
      ackLow  <= ackNext;
    end
  end

  always_comb begin
    nextState = state;
    cntNext   = bitCnt;
    idxNext   = byteIdx;
    ackNext   = ackLow;
    strobe    = '0;
    if (startSeen) begin
      nextState         = ST_ADDR;
      cntNext           = '0;
      strobe.clearShift = 1'b1;
    end else if (stopSeen) begin
      nextState = ST_IDLE;
      cntNext   = '0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            cntNext        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            cntNext   = '0;
            nextState = addrMatch ? ST_ADDR_ACK : ST_IGNORE;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            idxNext = '0;
            cntNext = '0;
            if (rwBit) begin
              nextState     = ST_RD_BYTE;
              strobe.txLoad = 1'b1;
            end else begin
              nextState         = ST_WR_BYTE;
              strobe.clearShift = 1'b1;
            end
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            cntNext        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            cntNext   = '0;
            nextState = ST_WR_ACK;
            if (byteIdx == 2'd0)      strobe.ptrLoad  = 1'b1;
            else if (byteIdx == 2'd1) strobe.regWrite = 1'b1;
            if (byteIdx != 2'd2) idxNext = byteIdx + 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            nextState         = ST_WR_BYTE;
            strobe.clearShift = 1'b1;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              nextState = ST_RD_ACK;
              cntNext   = '0;
            end else begin
              strobe.txShift = 1'b1;
              cntNext        = bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ackNext = ~sdaLvl;
          end else if (sclFall) begin
            if (ackLow) begin
              nextState     = ST_RD_BYTE;
              strobe.txLoad = 1'b1;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
    strobe.driveAck  = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
    strobe.driveData = (state == ST_RD_BYTE);
  end

  // R4: a STOP always lands in idle
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE));

  // R6: only one datapath action per cycle
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ptrLoad, strobe.regWrite, strobe.txLoad, strobe.txShift}));

  // R11: an ignored transaction never loads or writes
  assert_ignore_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !startSeen) |-> (!strobe.regWrite && !strobe.ptrLoad));

  // R9: bytes past the second never write
  assert_extra_discard_R9: assert property (@(posedge clk) disable iff (!rstN)
    (byteIdx == 2'd2) |-> !strobe.regWrite);

endmodule

// File: rtl/smbus_ptr_dp.sv
module smbus_ptr_dp
  import smbus_ptr_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter int         PTR_W       = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaLvl,
  input  logic [1:0]           strapCode,
  input  dpStrobe_t            strobe,
  input  logic [BYTE_BITS-1:0] regRdData,
  output logic                 addrMatch,
  output logic                 rwBit,
  output logic                 sdaDriveLow,
  output logic [PTR_W-1:0]     regAddr,
  output logic                 regWrEn,
  output logic [BYTE_BITS-1:0] regWrData
);

  logic [BYTE_BITS-1:0] shiftReg;
  logic [BYTE_BITS-1:0] txReg;
  logic [PTR_W-1:0]     pointer;
  logic [1:0]           devAddrLow;
  logic                 strapTaken;

  // Strap capture: once, on the first clock after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapTaken <= 1'b0;
      devAddrLow <= 2'b00;
    end else if (!strapTaken) begin
      strapTaken <= 1'b1;
      devAddrLow <= decodeStrap(strapCode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pointer <= '0;
    end else if (strobe.ptrLoad) begin
      pointer <= shiftReg[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '1;
    end else if (strobe.txLoad) begin
      txReg <= regRdData;
    end else if (strobe.txShift) begin
      txReg <= {txReg[BYTE_BITS-2:0], 1'b1};
    end
  end

  assign addrMatch   = strapTaken && (shiftReg[BYTE_BITS-1:1] == {ADDR_PREFIX, devAddrLow});
  assign rwBit       = shiftReg[0];
  assign sdaDriveLow = strobe.driveAck | (strobe.driveData & ~txReg[BYTE_BITS-1]);
  assign regAddr     = pointer;
  assign regWrEn     = strobe.regWrite;
  assign regWrData   = shiftReg;

  // R3: address bits frozen once captured
  assert_strap_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    strapTaken |=> $stable(devAddrLow));

  // R5: the ack and data drive are never requested together
  assert_drive_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.driveAck && strobe.driveData));

endmodule

// File: rtl/smbus_ptr_slave.sv
module smbus_ptr_slave
  import smbus_ptr_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [1:0]           strapCode,
  output logic                 sdaDriveLow,
  output logic [PTR_W-1:0]     regAddr,
  output logic                 regWrEn,
  output logic [BYTE_BITS-1:0] regWrData,
  input  logic [BYTE_BITS-1:0] regRdData
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic addrMatch, rwBit;
  dpStrobe_t strobe;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  smbus_ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .addrMatch(addrMatch), .rwBit(rwBit), .strobe(strobe)
  );

  smbus_ptr_dp #(.ADDR_PREFIX(ADDR_PREFIX), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .strapCode(strapCode),
    .strobe(strobe), .regRdData(regRdData), .addrMatch(addrMatch),
    .rwBit(rwBit), .sdaDriveLow(sdaDriveLow), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData)
  );

  // R4: the slave only moves SDA while the synchronized SCL is low
  assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLvl);

endmodule

// File: tb/smbus_ptr_slave_tb.sv
module smbus_ptr_slave_tb;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strapCode = 2'b01;
  logic sdaDriveLow;
  logic [7:0] regAddr;
  logic regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic sdaBus;

  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  int tests = 0;
  int fails = 0;
  int wrCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  smbus_ptr_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .strapCode(strapCode), .sdaDriveLow(sdaDriveLow), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    sclM = 1'b1;
    sdaM = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitQ;
    sclM = 1'b1; waitQ;
    sdaM = 1'b0; waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ;
    sclM = 1'b1; waitQ;
    sdaM = 1'b1; waitQ;
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ;
    sclM = 1'b1; waitQ; waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitQ;
    sclM = 1'b1; waitQ;
    b = sdaBus; waitQ;
    sclM = 1'b0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(1'b1);
  endtask

  task automatic writeReg(input logic [6:0] dev, input logic [7:0] ptr,
                          input logic [7:0] data, output logic allAck);
    logic a0, a1, a2;
    busStart;
    sendByte({dev, 1'b0}, a0);
    sendByte(ptr, a1);
    sendByte(data, a2);
    busStop;
    allAck = a0 & a1 & a2;
  endtask

  task automatic writePtr(input logic [6:0] dev, input logic [7:0] ptr);
    logic a0, a1;
    busStart;
    sendByte({dev, 1'b0}, a0);
    sendByte(ptr, a1);
    busStop;
  endtask

  task automatic readCur(input logic [6:0] dev, output logic [7:0] v);
    logic a0;
    busStart;
    sendByte({dev, 1'b1}, a0);
    recvByte(v);
    busStop;
  endtask

  task automatic probeAddr(input logic [6:0] dev, output logic acked);
    busStart;
    sendByte({dev, 1'b0}, acked);
    busStop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int wc;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i) ^ 8'hA5;
      expMem[i] = 8'(i) ^ 8'hA5;
    end

    // R1: reset state
    strapCode = 2'b01;
    doReset;
    chk(sdaDriveLow == 1'b0, "R1 sda released", int'(sdaDriveLow), 0);
    chk(regWrEn == 1'b0, "R1 no write", int'(regWrEn), 0);
    chk(regAddr == 8'h00, "R1 pointer zero", int'(regAddr), 0);

    // R2 / R11: all 128 addresses with the strap open
    for (int a = 0; a < 128; a++) begin
      probeAddr(7'(a), ack);
      chk(ack == (a == 8'h2E), $sformatf("R2 addr %0h ack", a), int'(ack), int'(a == 8'h2E));
    end

    // R2: grounded strap -> 0x2C
    strapCode = 2'b00;
    doReset;
    probeAddr(7'h2C, ack);
    chk(ack, "R2 ground strap own", int'(ack), 1);
    probeAddr(7'h2E, ack);
    chk(!ack, "R2 ground strap open addr", int'(ack), 0);

    // R3: a strap change after reset has no effect
    @(negedge clk);
    strapCode = 2'b10;
    repeat (10) @(negedge clk);
    probeAddr(7'h2C, ack);
    chk(ack, "R3 old address kept", int'(ack), 1);
    probeAddr(7'h2D, ack);
    chk(!ack, "R3 new strap ignored", int'(ack), 0);

    // R2: supply strap -> 0x2D after reset
    doReset;
    probeAddr(7'h2D, ack);
    chk(ack, "R2 supply strap own", int'(ack), 1);

    strapCode = 2'b11;
    doReset;
    probeAddr(7'h2E, ack);
    chk(ack, "R2 code 11 as open", int'(ack), 1);

    // R5 / R6: writes across pointer values, read back
    for (int i = 0; i < 16; i++) begin
      logic [7:0] p, d;
      p = 8'(i * 17 + 3);
      d = 8'(i * 29) ^ 8'h3C;
      wc = wrCount;
      writeReg(7'h2E, p, d, ack);
      expMem[p] = d;
      chk(ack, "R5 all bytes acked", int'(ack), 1);
      chk(wrCount == wc + 1, "R6 one write strobe", wrCount - wc, 1);
      chk(regAddr == p, "R6 pointer loaded", int'(regAddr), int'(p));
      readCur(7'h2E, rd);
      chk(rd == expMem[p], "R6 readback", int'(rd), int'(expMem[p]));
    end

    // R7: pointer-only write changes nothing
    wc = wrCount;
    writePtr(7'h2E, 8'h80);
    chk(wrCount == wc, "R7 no strobe", wrCount - wc, 0);
    readCur(7'h2E, rd);
    chk(rd == expMem[8'h80], "R7 register intact", int'(rd), int'(expMem[8'h80]));

    // R8: repeated reads without pointer write
    readCur(7'h2E, rd);
    chk(rd == expMem[8'h80], "R8 pointer retained", int'(rd), int'(expMem[8'h80]));

    // R9: extra bytes acked but discarded
    begin
      logic a0, a1, a2, a3, a4;
      wc = wrCount;
      busStart;
      sendByte({7'h2E, 1'b0}, a0);
      sendByte(8'h40, a1);
      sendByte(8'h11, a2);
      sendByte(8'h22, a3);
      sendByte(8'h33, a4);
      busStop;
      expMem[8'h40] = 8'h11;
      chk(a3 & a4, "R9 extra bytes acked", int'({a3, a4}), 3);
      chk(wrCount == wc + 1, "R9 single write", wrCount - wc, 1);
      chk(regAddr == 8'h40, "R9 pointer unchanged", int'(regAddr), 8'h40);
      readCur(7'h2E, rd);
      chk(rd == 8'h11, "R9 first data kept", int'(rd), 8'h11);
      writePtr(7'h2E, 8'h41);
      readCur(7'h2E, rd);
      chk(rd == expMem[8'h41], "R9 next reg untouched", int'(rd), int'(expMem[8'h41]));
    end

    // R10 / R12: pointer write, repeated START, read, NACK
    begin
      logic a0, a1, a2;
      busStart;
      sendByte({7'h2E, 1'b0}, a0);
      sendByte(8'h5A, a1);
      busStart;
      sendByte({7'h2E, 1'b1}, a2);
      chk(a2, "R10 read addr acked after Sr", int'(a2), 1);
      recvByte(rd);
      chk(rd == expMem[8'h5A], "R10 read after Sr", int'(rd), int'(expMem[8'h5A]));
      repeat (4) @(negedge clk);
      chk(sdaDriveLow == 1'b0, "R12 released after NACK", int'(sdaDriveLow), 0);
      busStop;
      repeat (4) @(negedge clk);
      chk(sdaDriveLow == 1'b0, "R4 idle after STOP", int'(sdaDriveLow), 0);
    end

    // R11: foreign address transaction has no effect
    begin
      logic a0, a1, a2;
      wc = wrCount;
      busStart;
      sendByte({7'h2F, 1'b0}, a0);
      sendByte(8'h10, a1);
      sendByte(8'hEE, a2);
      busStop;
      chk(!a0 && !a1 && !a2, "R11 no ack", int'({a0, a1, a2}), 0);
      chk(wrCount == wc, "R11 no write", wrCount - wc, 0);
      chk(regAddr == 8'h5A, "R11 pointer kept", int'(regAddr), 8'h5A);
      writePtr(7'h2E, 8'h10);
      readCur(7'h2E, rd);
      chk(rd == expMem[8'h10], "R11 register intact", int'(rd), int'(expMem[8'h10]));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule